// File: doc/BRIEF.md
# DSP Modulo Address Generator

This block works out the memory address and the written-back pointer value for one data-transfer access of a DSP datapath. There are three access paths. The X path serves the X-memory pointers, the Y path serves the Y-memory pointers, and the single path serves the general single-data moves. Each access gives the current pointer and an index operand. It also chooses an update kind: hold, add index, step up or step down.

On the X and Y paths the pointer can run inside a circular buffer. A packed boundary word supplies the start and the end of the buffer. Two enable bits choose which of the two paths is under modulo control, and Y wins when both bits are set. When a modulo-controlled pointer sits at the end address and moves forward, its low half is reloaded with the start address. The single path never wraps. On the single path, a step down is applied before the access and every other update is applied after it.

The results are registered, with one cycle from a request to its result.

Top module: `modulo_agu`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `res_valid`, `mem_addr` and `ptr_wb` are all zero.
- R2: `res_valid` is high in exactly the cycle after `req_valid` was sampled high. The result for a request appears on `mem_addr` and `ptr_wb` in that same cycle.
- R3: The update code 0 (hold) gives `ptr_wb` equal to `ptr_in` and `mem_addr` equal to `ptr_in`.
- R4: The update code 2 (step up) adds 2 on the X path (`path`=0) and on the Y path (`path`=1). On the single path (`path`=2 or 3) it adds 2 when `size_long`=0 and 4 when `size_long`=1. `mem_addr` is the old pointer.
- R5: The update code 3 (step down) subtracts the same step as R4. On the X and Y paths `mem_addr` is the old pointer. On the single path `mem_addr` equals the new pointer.
- R6: The update code 1 (add index) gives `ptr_wb` = `ptr_in` + `index_in` modulo 2^32, and `mem_addr` is the old pointer.
- R7: The boundary word holds the end address in bits 31:16 and the start address in bits 15:0. Modulo is active for an access in two cases: on the X path with `mod_x_en`=1 and `mod_y_en`=0, or on the Y path with `mod_y_en`=1. When modulo is active, the update is step up or add index, and `ptr_in[15:0]` equals the end address, then `ptr_wb` = {`ptr_in[31:16]`, start}.
- R8: When both enable bits are 1, an X-path access never wraps and a Y-path access wraps as in R7.
- R9: Single-path accesses never wrap, whatever the enable bits and the pointer value.
- R10: Hold and step-down updates never wrap, even at the end address with modulo active.
- R11: The end comparison uses only `ptr_in[15:0]`. A pointer whose low half differs from the end address takes the plain update, and the pointer's upper half never blocks a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| path | input | 2 | 0 X path, 1 Y path, 2 or 3 single path |
| upd | input | 2 | 0 hold, 1 add index, 2 step up, 3 step down |
| size_long | input | 1 | Single-path access size: 0 word, 1 longword |
| ptr_in | input | 32 | Current pointer value |
| index_in | input | 32 | Index operand for add-index |
| mod_x_en | input | 1 | Modulo enable for the X path |
| mod_y_en | input | 1 | Modulo enable for the Y path (has priority) |
| mod_bounds | input | 32 | End address [31:16], start address [15:0] |
| res_valid | output | 1 | Result valid |
| mem_addr | output | 32 | Address presented to memory |
| ptr_wb | output | 32 | Updated pointer to write back |

## Verification
The assertions expect every input to be a known value on each sampled edge while a request is raised. They also take the boundary word and the enable bits to be fixed for that edge, because each expected value is rebuilt from one cycle's sampled inputs. The bench drives all inputs on the falling edge and holds them through the rising edge, so each request sees one stable, fully defined set of operands. Every vector stays on defined path and update codes, and the wrap cases place the pointer exactly on the end address.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        PATH_X   = 2'd0,
        PATH_Y   = 2'd1,
        PATH_S   = 2'd2,
        PATH_S_B = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_INDEX = 2'd1,
        UPD_UP    = 2'd2,
        UPD_DOWN  = 2'd3
    } upd_e;

endpackage

// File: rtl/agu_step.sv
module agu_step
    import agu_pkg::*;
#(
    parameter int AW        = 32,
    parameter int WORD_STEP = 2,
    parameter int LONG_STEP = 4
) (
    input  logic [1:0]    upd,
    input  logic          single_path,
    input  logic          size_long,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] index_val,
    output logic [AW-1:0] raw_next,
    output logic          pre_update
);
    localparam logic [AW-1:0] WSTEP = AW'(WORD_STEP);
    localparam logic [AW-1:0] LSTEP = AW'(LONG_STEP);

    logic [AW-1:0] step_d;

    always_comb begin
        step_d = (single_path && size_long) ? LSTEP : WSTEP;
        unique case (upd_e'(upd))
            UPD_HOLD:  raw_next = ptr;
            UPD_INDEX: raw_next = ptr + index_val;
            UPD_UP:    raw_next = ptr + step_d;
            UPD_DOWN:  raw_next = ptr - step_d;
            default:   raw_next = ptr;
        endcase
        pre_update = single_path && (upd_e'(upd) == UPD_DOWN);
    end

endmodule

// File: rtl/agu_modsel.sv
module agu_modsel
    import agu_pkg::*;
(
    input  logic [1:0] path,
    input  logic [1:0] upd,
    input  logic       x_en,
    input  logic       y_en,
    output logic       wrap_allowed
);
    logic x_owner_d;
    logic y_owner_d;
    logic fwd_d;

    always_comb begin
        y_owner_d    = y_en;
        x_owner_d    = x_en && !y_en;
        fwd_d        = (upd_e'(upd) == UPD_UP) || (upd_e'(upd) == UPD_INDEX);
        wrap_allowed = 1'b0;
        unique case (path_e'(path))
            PATH_X:  wrap_allowed = x_owner_d && fwd_d;
            PATH_Y:  wrap_allowed = y_owner_d && fwd_d;
            default: wrap_allowed = 1'b0;
        endcase
    end

endmodule

// File: rtl/agu_wrap.sv
module agu_wrap #(
    parameter int AW = 32
) (
    input  logic          wrap_allowed,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] raw_next,
    input  logic [AW-1:0] bounds,
    output logic [AW-1:0] ptr_next,
    output logic          wrapped
);
    localparam int HW = AW / 2;

    logic [HW-1:0] end_lo;
    logic [HW-1:0] start_lo;

    always_comb begin
        end_lo   = bounds[AW-1:HW];
        start_lo = bounds[HW-1:0];
        wrapped  = wrap_allowed && (ptr[HW-1:0] == end_lo);
        ptr_next = wrapped ? {ptr[AW-1:HW], start_lo} : raw_next;
    end

endmodule

// File: rtl/modulo_agu.sv
module modulo_agu
    import agu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    path,
    input  logic [1:0]    upd,
    input  logic          size_long,
    input  logic [AW-1:0] ptr_in,
    input  logic [AW-1:0] index_in,
    input  logic          mod_x_en,
    input  logic          mod_y_en,
    input  logic [AW-1:0] mod_bounds,
    output logic          res_valid,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] ptr_wb
);
    localparam int HW = AW / 2;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [AW-1:0] ptr;
    } res_t;

    res_t          st_d, st_q;
    logic [AW-1:0] raw_next;
    logic          pre_update;
    logic          wrap_allowed;
    logic [AW-1:0] ptr_next;
    logic          wrapped;

    agu_step #(.AW(AW)) u_step (
        .upd         (upd),
        .single_path (path[1]),
        .size_long   (size_long),
        .ptr         (ptr_in),
        .index_val   (index_in),
        .raw_next    (raw_next),
        .pre_update  (pre_update)
    );

    agu_modsel u_modsel (
        .path         (path),
        .upd          (upd),
        .x_en         (mod_x_en),
        .y_en         (mod_y_en),
        .wrap_allowed (wrap_allowed)
    );

    agu_wrap #(.AW(AW)) u_wrap (
        .wrap_allowed (wrap_allowed),
        .ptr          (ptr_in),
        .raw_next     (raw_next),
        .bounds       (mod_bounds),
        .ptr_next     (ptr_next),
        .wrapped      (wrapped)
    );

    always_comb begin
        st_d = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.ptr  = ptr_next;
            st_d.addr = pre_update ? ptr_next : ptr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign mem_addr  = st_q.addr;
    assign ptr_wb    = st_q.ptr;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid) else $error("valid not raised"); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid) else $error("valid not dropped"); // R2
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && upd == 2'd0) |=> (ptr_wb == $past(ptr_in) && mem_addr == $past(ptr_in)))
        else $error("hold changed pointer"); // R3
    AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && upd != 2'd3) |=> (mem_addr == $past(ptr_in)))
        else $error("post-update address wrong"); // R6
    AST_SINGLE_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && path[1] && upd == 2'd2 && size_long) |=> (ptr_wb == $past(ptr_in) + AW'(4)))
        else $error("single path wrapped"); // R9
    AST_X_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && path == 2'd0 && mod_x_en && mod_y_en && upd == 2'd2)
        |=> (ptr_wb == $past(ptr_in) + AW'(2)))
        else $error("X wrapped while Y owns modulo"); // R8
    AST_Y_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && path == 2'd1 && mod_y_en && upd == 2'd2 && ptr_in[HW-1:0] == mod_bounds[AW-1:HW])
        |=> (ptr_wb == {$past(ptr_in[AW-1:HW]), $past(mod_bounds[HW-1:0])}))
        else $error("Y did not wrap"); // R7
    AST_DOWN_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && upd == 2'd3) |-> !wrapped) else $error("step down wrapped"); // R10

endmodule

// File: tb/modulo_agu_test.sv
module modulo_agu_test;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  path;
        logic [1:0]  upd;
        logic        lng;
        logic        xen;
        logic        yen;
        logic [31:0] ptr;
        logic [31:0] idx;
        logic [31:0] bnd;
        logic [31:0] eaddr;
        logic [31:0] eptr;
    } vec_t;

    localparam logic [31:0] MB = 32'h1040_1000;
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R3 hold
        '{4'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0020_1234, 32'h0, MB, 32'h0020_1234, 32'h0020_1234},
        // R4 step up on X, single word, single long
        '{4'd4, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_1000, 32'h0, MB, 32'h0000_1000, 32'h0000_1002},
        '{4'd4, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_2000, 32'h0, MB, 32'h0000_2000, 32'h0000_2002},
        '{4'd4, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 32'h0, MB, 32'h0000_2000, 32'h0000_2004},
        // R5 step down: X post, single pre word/long
        '{4'd5, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_3000, 32'h0, MB, 32'h0000_3000, 32'h0000_2FFE},
        '{4'd5, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_3000, 32'h0, MB, 32'h0000_2FFE, 32'h0000_2FFE},
        '{4'd5, 2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_3000, 32'h0, MB, 32'h0000_2FFC, 32'h0000_2FFC},
        // R6 add index, positive and negative
        '{4'd6, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_4000, 32'h10, MB, 32'h0000_4000, 32'h0000_4010},
        '{4'd6, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_5000, 32'hFFFF_FFF0, MB, 32'h0000_5000, 32'h0000_4FF0},
        // R7 wrap on X step up, Y add index
        '{4'd7, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 32'h00A5_1040, 32'h0, MB, 32'h00A5_1040, 32'h00A5_1000},
        '{4'd7, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_1040, 32'h20, MB, 32'h0000_1040, 32'h0000_1000},
        // R8 both enables: X plain, Y wraps
        '{4'd8, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_1040, 32'h0, MB, 32'h0000_1040, 32'h0000_1042},
        '{4'd8, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_1040, 32'h0, MB, 32'h0000_1040, 32'h0000_1000},
        // R9 single path never wraps
        '{4'd9, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0000_1040, 32'h0, MB, 32'h0000_1040, 32'h0000_1044},
        // R10 step down and hold never wrap
        '{4'd10, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 32'h0000_1040, 32'h0, MB, 32'h0000_1040, 32'h0000_103E},
        '{4'd10, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_1040, 32'h0, MB, 32'h0000_1040, 32'h0000_1040},
        // R11 low half off the end; upper half ignored in compare
        '{4'd11, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_1038, 32'h0, MB, 32'h0000_1038, 32'h0000_103A},
        '{4'd11, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 32'hFFFF_1040, 32'h0, MB, 32'hFFFF_1040, 32'hFFFF_1000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  path = '0;
    logic [1:0]  upd = '0;
    logic        size_long = 1'b0;
    logic [31:0] ptr_in = '0;
    logic [31:0] index_in = '0;
    logic        mod_x_en = 1'b0;
    logic        mod_y_en = 1'b0;
    logic [31:0] mod_bounds = '0;
    logic        res_valid;
    logic [31:0] mem_addr;
    logic [31:0] ptr_wb;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    modulo_agu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .path       (path),
        .upd        (upd),
        .size_long  (size_long),
        .ptr_in     (ptr_in),
        .index_in   (index_in),
        .mod_x_en   (mod_x_en),
        .mod_y_en   (mod_y_en),
        .mod_bounds (mod_bounds),
        .res_valid  (res_valid),
        .mem_addr   (mem_addr),
        .ptr_wb     (ptr_wb)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        req_valid  = 1'b1;
        path       = v.path;
        upd        = v.upd;
        size_long  = v.lng;
        ptr_in     = v.ptr;
        index_in   = v.idx;
        mod_x_en   = v.xen;
        mod_y_en   = v.yen;
        mod_bounds = v.bnd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk($sformatf("R%0d", v.req), "addr", mem_addr, v.eaddr);
        chk($sformatf("R%0d", v.req), "ptr", ptr_wb, v.eptr);
        chk("R2", "valid", {31'b0, res_valid}, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 outputs cleared under reset
        chk("R1", "valid", {31'b0, res_valid}, 32'd0);
        chk("R1", "addr", mem_addr, 32'd0);
        chk("R1", "ptr", ptr_wb, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid idle", {31'b0, res_valid}, 32'd0);
        chk("R1", "ptr idle", ptr_wb, 32'd0);

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R2 no request: valid drops the next cycle
        @(negedge clk);
        chk("R2", "valid low", {31'b0, res_valid}, 32'd0);

        // R2 back-to-back requests each produce a result one cycle later
        @(negedge clk);
        req_valid = 1'b1; path = 2'd0; upd = 2'd2; mod_x_en = 1'b0; mod_y_en = 1'b0;
        ptr_in = 32'h0000_0100; mod_bounds = MB;
        @(negedge clk);
        chk("R2", "b2b first", ptr_wb, 32'h0000_0102);
        ptr_in = 32'h0000_0200;
        @(negedge clk);
        chk("R2", "b2b second", ptr_wb, 32'h0000_0202);
        chk("R2", "b2b valid", {31'b0, res_valid}, 32'd1);
        req_valid = 1'b0;

        // R1 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "reset addr", mem_addr, 32'd0);
        chk("R1", "reset valid", {31'b0, res_valid}, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule